// File: doc/BRIEF.md
# Serial-to-Parallel Word Converter with Bit Slip

This block turns a serial NRZ bit stream into parallel words of `WORD_W` bits, four by default. It runs entirely on the bit-rate clock. A small counter sets the word boundaries, and the same counter drives two divided clock outputs: one at the word rate (bit clock / `WORD_W`) and one at half that rate (bit clock / `2*WORD_W`). The half-rate output supports a two-device cascade. The earliest bit of each word appears on bit 0 of the parallel output, and later bits fill the higher positions in order.

A select line picks one of two serial sources, so the second source can act as a test loopback path. The chosen stream also leaves the block on a serial output after one register stage, for chaining into a second device. A cadence input makes the parallel word update either once per word period or once per double period, for the cascaded scheme.

Word alignment is trimmed with an asynchronous slip input. The input passes through a synchronizer and a rising-edge detector. Each pulse then makes the divider stand still for one bit time. That one swallowed clock moves the word boundary by one bit, so data that used to land on output bit n lands on bit n-1.

Top module: `bitslip_deser`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge sets `word_out` to zero, sets `clk_word` and `clk_pair` high and sets `ser_out` low.
- R2: With `cadence`=0, a word is loaded at every fourth counting edge after reset, beginning with the fourth. `word_out[0]` holds the bit sampled earliest in that group and `word_out[3]` the bit sampled at the loading edge.
- R3: `word_out` changes only at a loading edge. With `cadence`=0 a load happens when the divider count is at 3, 7 and so on; with `cadence`=1 it happens only when the count is at 7. Between loads `word_out` holds its value.
- R4: The divider count runs 0 to 7 and wraps. `clk_word` is high for counts 0–1 and 4–5 and low otherwise. `clk_pair` is high for counts 0–3 and low for counts 4–7.
- R5: `src_sel`=0 routes `ser_a` into the converter and `src_sel`=1 routes `ser_b`. The source that is not selected has no effect on `word_out` or `ser_out`.
- R6: `ser_out` equals the selected serial input sampled at the previous rising clock edge.
- R7: A rising edge on `slip_req` that is held high for at least two clocks freezes the divider count for exactly one edge, two edges after the rise is first sampled. No load happens at the frozen edge, and later words are shifted by one bit toward bit 0. A long pulse gives exactly one slip.
- R8: A reset applied in the middle of operation returns the divider count to 0, so the next word again spans the four edges after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_a | input | 1 | Serial data source A |
| ser_b | input | 1 | Serial data source B (loopback) |
| src_sel | input | 1 | 0 selects A, 1 selects B |
| cadence | input | 1 | 0: update every word period; 1: every double period |
| slip_req | input | 1 | Asynchronous alignment slip request, one bit per pulse |
| ser_out | output | 1 | Selected serial data delayed one clock |
| word_out | output | WORD_W | Parallel word, earliest bit at index 0 |
| clk_word | output | 1 | Divide-by-WORD_W clock |
| clk_pair | output | 1 | Divide-by-2*WORD_W clock |

## Verification
The bench builds the block with its default values: `WORD_W`=4 and `SYNC_STAGES`=2. With these values the 3-bit divider wraps every eight bit times, so every count value, both update cadences and all four slip phases come up many times in a few hundred cycles. A slip can land on a terminal count, on a count in the middle of a word and inside a double-period cycle; the bench reaches each of these positions and checks the word placement after every one. It also checks that a long pulse slips only once and that a reset in mid-stream brings back the original word framing.

// File: rtl/bitslip_deser_pkg.sv
package bitslip_deser_pkg;
  // Output update cadence: once per word period, or once per double period
  typedef enum logic {
    CAD_SINGLE = 1'b0,
    CAD_PAIR   = 1'b1
  } cadence_e;
endpackage

// File: rtl/bitslip_sync_edge.sv
module bitslip_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  // bits [STAGES-1:0] form the synchronizer, bit STAGES is the edge-detect delay
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/bitslip_divider.sv
module bitslip_divider
  import bitslip_deser_pkg::*;
#(
  parameter int WORD_W = 4,
  localparam int CNT_W = $clog2(2 * WORD_W),
  localparam int SUB_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  cadence_e         cadence,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             div_word_o,
  output logic             div_pair_o
);
  logic [CNT_W-1:0] cnt;
  logic             at_term;

  always_comb begin
    if (cadence == CAD_PAIR) at_term = &cnt;
    else                     at_term = &cnt[SUB_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (!hold) cnt <= cnt + 1'b1;
  end

  assign load_o     = at_term & ~hold;
  assign cnt_o      = cnt;
  assign div_word_o = ~cnt[SUB_W-1];
  assign div_pair_o = ~cnt[CNT_W-1];
endmodule

// File: rtl/bitslip_shifter.sv
module bitslip_shifter #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              load,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_nxt;

  // newest bit enters at the top, so the earliest bit reaches index 0
  assign shreg_nxt = {bit_in, shreg[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      word_o <= '0;
    end else begin
      shreg <= shreg_nxt;
      if (load) word_o <= shreg_nxt;
    end
  end
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import bitslip_deser_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(2 * WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_a,
  input  logic              ser_b,
  input  logic              src_sel,
  input  logic              cadence,
  input  logic              slip_req,
  output logic              ser_out,
  output logic [WORD_W-1:0] word_out,
  output logic              clk_word,
  output logic              clk_pair
);
  logic             ser_bit;
  logic             slip_pulse;
  logic             word_load;
  logic [CNT_W-1:0] div_cnt;

  assign ser_bit = src_sel ? ser_b : ser_a;

  always_ff @(posedge clk) begin
    if (rst) ser_out <= 1'b0;
    else     ser_out <= ser_bit;
  end

  bitslip_sync_edge #(.STAGES(SYNC_STAGES)) slip_sync_i (
    .clk        (clk),
    .rst        (rst),
    .async_in   (slip_req),
    .rise_pulse (slip_pulse)
  );

  bitslip_divider #(.WORD_W(WORD_W)) div_i (
    .clk        (clk),
    .rst        (rst),
    .hold       (slip_pulse),
    .cadence    (cadence_e'(cadence)),
    .cnt_o      (div_cnt),
    .load_o     (word_load),
    .div_word_o (clk_word),
    .div_pair_o (clk_pair)
  );

  bitslip_shifter #(.WORD_W(WORD_W)) shift_i (
    .clk    (clk),
    .rst    (rst),
    .bit_in (ser_bit),
    .load   (word_load),
    .word_o (word_out)
  );
endmodule

// File: rtl/bitslip_deser_chk.sv
module bitslip_deser_chk #(
  parameter int WORD_W = 4,
  localparam int CNT_W = $clog2(2 * WORD_W),
  localparam int SUB_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_a,
  input logic              ser_b,
  input logic              src_sel,
  input logic              cadence,
  input logic              ser_out,
  input logic [WORD_W-1:0] word_out,
  input logic              clk_word,
  input logic              clk_pair,
  input logic [CNT_W-1:0]  cnt,
  input logic              slip
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * WORD_W - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(WORD_W - 1);

  logic may_load;
  assign may_load = cadence ? (cnt == CNT_LAST) : (cnt[SUB_W-1:0] == SUB_LAST);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (word_out == '0 && clk_word && clk_pair && !ser_out));

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (slip || !may_load) |=> $stable(word_out));

  assert_div_phase_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_pair) |-> $rose(clk_word));

  assert_ser_delay_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ser_out == $past(src_sel ? ser_b : ser_a));

  assert_slip_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    slip |=> $stable(cnt));

  assert_slip_single_R7: assert property (@(posedge clk) disable iff (rst)
    slip |=> !slip);

  assert_reset_count_R8: assert property (@(posedge clk)
    rst |=> cnt == '0);
endmodule

bind bitslip_deser bitslip_deser_chk #(.WORD_W(WORD_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ser_a    (ser_a),
  .ser_b    (ser_b),
  .src_sel  (src_sel),
  .cadence  (cadence),
  .ser_out  (ser_out),
  .word_out (word_out),
  .clk_word (clk_word),
  .clk_pair (clk_pair),
  .cnt      (div_cnt),
  .slip     (slip_pulse)
);

// File: tb/bitslip_deser_tb.sv
module bitslip_deser_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_a = 1'b0, ser_b = 1'b0, src_sel = 1'b0, cadence = 1'b0, slip_req = 1'b0;
  logic       ser_out, clk_word, clk_pair;
  logic [3:0] word_out;

  always #5 clk = ~clk;

  bitslip_deser dut_i (
    .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b), .src_sel(src_sel),
    .cadence(cadence), .slip_req(slip_req), .ser_out(ser_out),
    .word_out(word_out), .clk_word(clk_word), .clk_pair(clk_pair)
  );

  typedef struct {
    int         idx;
    logic [3:0] word;
    logic       dw, dp, so;
    string      wtag, stag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   checks = 0, fails = 0;
  int   pe = 0;

  // reference state, built from the requirements
  int         edge_n = 0, slip_at = -1;
  logic [2:0] mcnt = '0;
  logic [3:0] hist = '0, eword = '0;
  logic       prev_sync = 1'b0;
  logic [7:0] lf = 8'hA5;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic nb(output logic b);
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    b  = lf[0];
  endtask

  // driver: apply inputs for the next edge, push what that edge must produce
  task automatic step(input logic a, input logic b, input logic sel, input logic mode,
                      input logic sync, input string wtag, input string stag);
    logic       sin, hold;
    logic [3:0] nh;
    exp_t       e;
    ser_a = a; ser_b = b; src_sel = sel; cadence = mode; slip_req = sync;
    sin = sel ? b : a;
    if (sync && !prev_sync) slip_at = edge_n + 2;
    prev_sync = sync;
    hold = (edge_n == slip_at);
    nh = {sin, hist[3:1]};
    if (!hold && (mode ? (mcnt == 3'd7) : (mcnt[1:0] == 2'd3))) eword = nh;
    hist = nh;
    if (!hold) mcnt = mcnt + 3'd1;
    e.idx = edge_n; e.word = eword; e.dw = ~mcnt[1]; e.dp = ~mcnt[2]; e.so = sin;
    e.wtag = wtag; e.stag = stag;
    q.push_back(e);
    edge_n++;
    @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; slip_req = 1'b0; ser_a = 1'b0; ser_b = 1'b0;
    @(negedge clk);
    @(negedge clk);
    q.delete();
    chk({tag, " word_out"}, 32'(word_out), 32'h0);
    chk({tag, " clk_word"}, 32'(clk_word), 32'h1);
    chk({tag, " clk_pair"}, 32'(clk_pair), 32'h1);
    chk({tag, " ser_out"},  32'(ser_out),  32'h0);
    edge_n = 0; slip_at = -1; mcnt = '0; hist = '0; eword = '0; prev_sync = 1'b0;
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rst) pe <= 0;
    else     pe <= pe + 1;
  end

  // monitor: compare each edge's outputs with the queued expectation
  always @(negedge clk) begin
    if (!rst && pe > 0 && q.size() > 0) begin
      mon_e = q.pop_front();
      chk("scoreboard order", 32'(mon_e.idx), 32'(pe - 1));
      chk({mon_e.wtag, " word_out"}, 32'(word_out), 32'(mon_e.word));
      chk("R4 clk_word", 32'(clk_word), 32'(mon_e.dw));
      chk("R4 clk_pair", 32'(clk_pair), 32'(mon_e.dp));
      chk({mon_e.stag, " ser_out"}, 32'(ser_out), 32'(mon_e.so));
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic b;
    repeat (3) @(negedge clk);
    do_reset("R1");
    // R2: plain word assembly from source A
    for (int i = 0; i < 32; i++) begin nb(b); step(b, 1'b0, 1'b0, 1'b0, 1'b0, "R2", "R6"); end
    // R5: source B selected, source A driven with the inverse
    for (int i = 0; i < 24; i++) begin nb(b); step(~b, b, 1'b1, 1'b0, 1'b0, "R5", "R5"); end
    // R7: three short slip pulses at different word phases
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 11 + k; i++) begin
        nb(b); step(b, 1'b0, 1'b0, 1'b0, (i < 3), "R7", "R6");
      end
    end
    // R7: one long pulse gives a single slip
    for (int i = 0; i < 24; i++) begin nb(b); step(b, 1'b0, 1'b0, 1'b0, (i < 14), "R7", "R6"); end
    // R3: double-period cadence, with a slip inside it
    for (int i = 0; i < 48; i++) begin
      nb(b); step(b, 1'b0, 1'b0, 1'b1, (i >= 20 && i < 23), "R3", "R6");
    end
    // R8: reset mid-stream, then framing restarts
    do_reset("R8");
    for (int i = 0; i < 16; i++) begin nb(b); step(b, 1'b0, 1'b0, 1'b0, 1'b0, "R8", "R6"); end
    finish_run();
  end
endmodule